// File: doc/BRIEF.md
# Transmit Serial Payload Input Port for T1/E1 Framing

This block sits at the entrance of a T1 or E1 transmit framer. Payload bits arrive one per period of a transmit serial clock on a single data pin. The serial clock is oversampled by the system clock, and a bit is taken on whichever clock edge the configuration selects. For every captured bit the block keeps track of where it falls in the outbound frame: T1 frames have 193 bits, a framing bit followed by 24 channels of eight bits, and E1 frames have 256 bits in 32 slots of eight bits. It reports the slot and the bit index of that bit, marks overhead positions, and says whether the bit on the wire is to be used or replaced by internally generated overhead.

Frame alignment comes from one of two roles. In the slave role, where the serial clock is the transmit timing source, an external one-period frame pulse marks the first bit of a frame. In the master role, where the timing is taken from a recovered or master clock, the block drives that pulse itself and enables its output driver. A bypass mode stops framing altogether. It passes the data pin, the frame pulse pin and the serial clock straight through to the positive rail, the negative rail and the line clock of the line interface.

Top module: `tx_serial_in`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `out_sof`, `out_resync`, `out_data`, `out_slot`, `out_bit`, `out_use_in`, `out_oh` and `out_kind` are all 0, and the next bit position is 0.
- R2: When `fall_edge`=0 a bit is captured on each 0-to-1 change of `ser_clk`; when `fall_edge`=1 it is captured on each 1-to-0 change. The captured value appears on `out_data`, and `out_valid` is high for exactly one system clock, in the cycle after the system clock edge that sees the change.
- R3: With `t1_mode`=1 positions run 0..192 and then wrap. Position 0 is the framing bit and is reported as slot 24, bit 0, `out_oh`=1. Position p≥1 is reported as slot (p-1)/8, bit (p-1)%8, `out_oh`=0, `out_use_in`=1.
- R4: With `t1_mode`=0 positions run 0..255 and then wrap, and position p is reported as slot p/8, bit p%8.
- R5: In the slave role (`master`=0), a bit captured while `sync_in`=1 is position 0. If the expected position was not 0, `out_resync` pulses together with that bit.
- R6: In the master role (`master`=1) with `bypass`=0, `sync_oe`=1 and `sync_in` has no effect. `sync_out` is high exactly while the next bit to be captured is position 0, which lasts one serial clock period. Otherwise `sync_oe`=0 and `sync_out`=0.
- R7: In E1, slots 0 and 16 have `out_oh`=1 and take `out_use_in`=`e1_oh_en`. All other slots have `out_oh`=0 and `out_use_in`=1.
- R8: In T1 a multiframe counter numbers frames 0..23. The first frame after reset is 0, and the counter advances on every captured position 0. The framing bit of frame f has `out_kind` 2 (data link) when f%4 is 0 or 2, 3 (CRC-6) when f%4=1, and 1 (alignment) when f%4=3. Its `out_use_in` equals `t1_dl_en`, `t1_crc_en` or `t1_fas_en` respectively. Every other bit has `out_kind` 0.
- R9: With `bypass`=1, `rail_p`=`ser_data`, `rail_n`=`sync_in` and `line_clk`=`ser_clk`, and no bit is captured. With `bypass`=0 those three outputs are 0.
- R10: `out_sof` pulses with `out_valid` exactly when the captured bit is position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| t1_mode | input | 1 | 1 = 193-bit T1 frame, 0 = 256-bit E1 frame |
| fall_edge | input | 1 | Capture edge select: 0 rising, 1 falling |
| master | input | 1 | 1 = block generates frame pulse, 0 = frame pulse is an input |
| bypass | input | 1 | Route pins straight to the line rails |
| t1_fas_en | input | 1 | T1 alignment framing bits taken from input |
| t1_dl_en | input | 1 | T1 data-link framing bits taken from input |
| t1_crc_en | input | 1 | T1 CRC-6 framing bits taken from input |
| e1_oh_en | input | 1 | E1 slots 0 and 16 taken from input |
| ser_clk | input | 1 | Transmit serial clock |
| ser_data | input | 1 | Transmit serial data |
| sync_in | input | 1 | Frame pulse input (slave role) |
| sync_out | output | 1 | Frame pulse output (master role) |
| sync_oe | output | 1 | Output enable for the frame pulse pin |
| out_valid | output | 1 | One-cycle strobe for a captured bit |
| out_data | output | 1 | Captured bit value |
| out_slot | output | 5 | Slot or channel of the captured bit (24 = T1 framing bit) |
| out_bit | output | 3 | Bit index within the slot |
| out_sof | output | 1 | Captured bit is frame position 0 |
| out_use_in | output | 1 | 1 = use the input bit, 0 = replace with internal overhead |
| out_oh | output | 1 | Captured bit is an overhead position |
| out_kind | output | 2 | T1 framing bit class: 0 none, 1 alignment, 2 data link, 3 CRC-6 |
| out_resync | output | 1 | Frame pulse arrived away from the expected wrap |
| line_clk | output | 1 | Line clock in bypass |
| rail_p | output | 1 | Positive line rail in bypass |
| rail_n | output | 1 | Negative line rail in bypass |

## Verification
T1 traffic runs in the slave role with frame pulses on every wrap. One pulse is then placed 50 bits into a frame, and the line is later left without any pulse across a wrap. This tells a clean realignment apart from a forced one, and from a free-running wrap. E1 traffic uses the falling edge, with slot 0/16 insertion both off and on, and the position mapping and the overhead source are checked on every bit. A 25-frame T1 run in the master role, with random noise on the frame pulse input, walks the whole multiframe, so each framing bit class and its enable is seen with the input pulse ignored. A bypass run with random data, pulse and clock levels tells the rail routing apart from any capture activity.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
    localparam int T1_BITS       = 193;
    localparam int E1_BITS       = 256;
    localparam int MF_FRAMES     = 24;
    localparam int POS_W         = $clog2(E1_BITS);
    localparam int MF_W          = $clog2(MF_FRAMES);
    localparam int BIT_W         = 3;
    localparam int SLOT_W        = 5;
    localparam int T1_FBIT_SLOT  = 24;
    localparam int E1_ALIGN_SLOT = 0;
    localparam int E1_SIG_SLOT   = 16;

    typedef enum logic [1:0] {
        FB_NONE  = 2'd0,
        FB_ALIGN = 2'd1,
        FB_LINK  = 2'd2,
        FB_CRC   = 2'd3
    } fbit_e;

    typedef struct packed {
        logic              valid;
        logic              data;
        logic [SLOT_W-1:0] slot;
        logic [BIT_W-1:0]  bidx;
        logic              sof;
        logic              use_in;
        logic              oh;
        fbit_e             kind;
        logic              resync;
    } cap_t;
endpackage

// File: rtl/tsi_edge.sv
module tsi_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_clk,
    input  logic fall_edge,
    output logic edge_pulse
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d     = ser_clk;
        edge_pulse = fall_edge ? (prev_q & ~ser_clk) : (~prev_q & ser_clk);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/tsi_count.sv
module tsi_count #(
    parameter int T1_BITS   = tsi_pkg::T1_BITS,
    parameter int E1_BITS   = tsi_pkg::E1_BITS,
    parameter int MF_FRAMES = tsi_pkg::MF_FRAMES
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cap,
    input  logic                     sync_hit,
    input  logic                     t1_mode,
    output logic [tsi_pkg::POS_W-1:0] cur_pos,
    output logic [tsi_pkg::MF_W-1:0]  cur_mf,
    output logic                     resync,
    output logic                     next_is_first
);
    localparam int PW = tsi_pkg::POS_W;
    localparam int MW = tsi_pkg::MF_W;
    localparam logic [PW-1:0] T1_LAST = PW'(T1_BITS - 1);
    localparam logic [PW-1:0] E1_LAST = PW'(E1_BITS - 1);
    localparam logic [MW-1:0] MF_LAST = MW'(MF_FRAMES - 1);

    typedef struct packed {
        logic [PW-1:0] pos;
        logic [MW-1:0] mf;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d   = cnt_q;
        cur_pos = cnt_q.pos;
        cur_mf  = cnt_q.mf;
        resync  = 1'b0;
        if (cap) begin
            if (sync_hit) begin
                cur_pos = '0;
                resync  = (cnt_q.pos != '0);
            end
            if (cur_pos == '0)
                cur_mf = (cnt_q.mf == MF_LAST) ? '0 : cnt_q.mf + MW'(1);
            cnt_d.mf  = cur_mf;
            cnt_d.pos = (cur_pos == (t1_mode ? T1_LAST : E1_LAST)) ? '0 : cur_pos + PW'(1);
        end
        next_is_first = (cnt_q.pos == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q.pos <= '0;
            cnt_q.mf  <= MF_LAST;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/tsi_class.sv
module tsi_class
    import tsi_pkg::*;
(
    input  logic [POS_W-1:0]  pos,
    input  logic [MF_W-1:0]   mf,
    input  logic              t1_mode,
    input  logic              t1_fas_en,
    input  logic              t1_dl_en,
    input  logic              t1_crc_en,
    input  logic              e1_oh_en,
    output logic [SLOT_W-1:0] slot,
    output logic [BIT_W-1:0]  bidx,
    output logic              oh,
    output logic              use_in,
    output fbit_e             kind
);
    logic [POS_W-1:0] pm1;
    logic [1:0]       grp;

    always_comb begin
        pm1    = pos - POS_W'(1);
        grp    = 2'(mf % MF_W'(4));
        slot   = '0;
        bidx   = '0;
        oh     = 1'b0;
        use_in = 1'b1;
        kind   = FB_NONE;
        if (t1_mode) begin
            if (pos == '0) begin
                slot = SLOT_W'(T1_FBIT_SLOT);
                oh   = 1'b1;
                case (grp)
                    2'd1:    begin kind = FB_CRC;   use_in = t1_crc_en; end
                    2'd3:    begin kind = FB_ALIGN; use_in = t1_fas_en; end
                    default: begin kind = FB_LINK;  use_in = t1_dl_en;  end
                endcase
            end else begin
                slot = SLOT_W'(pm1 >> BIT_W);
                bidx = pm1[BIT_W-1:0];
            end
        end else begin
            slot = SLOT_W'(pos >> BIT_W);
            bidx = pos[BIT_W-1:0];
            if (slot == SLOT_W'(E1_ALIGN_SLOT) || slot == SLOT_W'(E1_SIG_SLOT)) begin
                oh     = 1'b1;
                use_in = e1_oh_en;
            end
        end
    end
endmodule

// File: rtl/tx_serial_in.sv
module tx_serial_in
    import tsi_pkg::*;
#(
    parameter int T1_LEN = tsi_pkg::T1_BITS,
    parameter int E1_LEN = tsi_pkg::E1_BITS,
    parameter int MF_LEN = tsi_pkg::MF_FRAMES
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        t1_mode,
    input  logic        fall_edge,
    input  logic        master,
    input  logic        bypass,
    input  logic        t1_fas_en,
    input  logic        t1_dl_en,
    input  logic        t1_crc_en,
    input  logic        e1_oh_en,
    input  logic        ser_clk,
    input  logic        ser_data,
    input  logic        sync_in,
    output logic        sync_out,
    output logic        sync_oe,
    output logic        out_valid,
    output logic        out_data,
    output logic [4:0]  out_slot,
    output logic [2:0]  out_bit,
    output logic        out_sof,
    output logic        out_use_in,
    output logic        out_oh,
    output logic [1:0]  out_kind,
    output logic        out_resync,
    output logic        line_clk,
    output logic        rail_p,
    output logic        rail_n
);
    logic              bit_edge, cap, resync_now, first_next;
    logic [POS_W-1:0]  cur_pos;
    logic [MF_W-1:0]   cur_mf;
    logic [SLOT_W-1:0] c_slot;
    logic [BIT_W-1:0]  c_bidx;
    logic              c_oh, c_use;
    fbit_e             c_kind;
    cap_t              out_d, out_q;

    tsi_edge u_edge (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk),
        .fall_edge(fall_edge), .edge_pulse(bit_edge)
    );

    assign cap = bit_edge & ~bypass;

    tsi_count #(.T1_BITS(T1_LEN), .E1_BITS(E1_LEN), .MF_FRAMES(MF_LEN)) u_count (
        .clk(clk), .rst_n(rst_n), .cap(cap), .sync_hit(~master & sync_in),
        .t1_mode(t1_mode), .cur_pos(cur_pos), .cur_mf(cur_mf),
        .resync(resync_now), .next_is_first(first_next)
    );

    tsi_class u_class (
        .pos(cur_pos), .mf(cur_mf), .t1_mode(t1_mode),
        .t1_fas_en(t1_fas_en), .t1_dl_en(t1_dl_en), .t1_crc_en(t1_crc_en),
        .e1_oh_en(e1_oh_en), .slot(c_slot), .bidx(c_bidx),
        .oh(c_oh), .use_in(c_use), .kind(c_kind)
    );

    always_comb begin
        out_d        = out_q;
        out_d.valid  = 1'b0;
        out_d.sof    = 1'b0;
        out_d.resync = 1'b0;
        if (cap) begin
            out_d.valid  = 1'b1;
            out_d.data   = ser_data;
            out_d.slot   = c_slot;
            out_d.bidx   = c_bidx;
            out_d.sof    = (cur_pos == '0);
            out_d.use_in = c_use;
            out_d.oh     = c_oh;
            out_d.kind   = c_kind;
            out_d.resync = resync_now;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q      <= '0;
            out_q.kind <= FB_NONE;
        end else begin
            out_q <= out_d;
        end
    end

    assign sync_oe    = master & ~bypass;
    assign sync_out   = sync_oe & first_next;
    assign out_valid  = out_q.valid;
    assign out_data   = out_q.data;
    assign out_slot   = out_q.slot;
    assign out_bit    = out_q.bidx;
    assign out_sof    = out_q.sof;
    assign out_use_in = out_q.use_in;
    assign out_oh     = out_q.oh;
    assign out_kind   = out_q.kind;
    assign out_resync = out_q.resync;
    assign line_clk   = bypass & ser_clk;
    assign rail_p     = bypass & ser_data;
    assign rail_n     = bypass & sync_in;
endmodule

// File: rtl/tsi_chk.sv
module tsi_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       master,
    input logic       bypass,
    input logic       sync_oe,
    input logic       sync_out,
    input logic       out_valid,
    input logic       out_sof,
    input logic       out_resync,
    input logic       out_use_in,
    input logic       out_oh,
    input logic [1:0] out_kind
);
    AST_RESYNC_ON_FRAME_START: assert property (@(posedge clk) disable iff (!rst_n)
        out_resync |-> (out_valid && out_sof)); // R5
    AST_SOF_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |-> out_valid); // R10
    AST_PAYLOAD_FROM_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_oh) |-> out_use_in); // R7
    AST_KIND_IS_OVERHEAD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_kind != 2'd0) |-> out_oh); // R8
    AST_SYNC_DRIVER_ROLE: assert property (@(posedge clk) disable iff (!rst_n)
        sync_oe |-> (master && !bypass)); // R6
    AST_SYNC_OUT_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        sync_out |-> sync_oe); // R6
    AST_BYPASS_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (bypass && $past(bypass)) |-> !out_valid); // R9
endmodule

bind tx_serial_in tsi_chk u_chk (
    .clk(clk), .rst_n(rst_n), .master(master), .bypass(bypass),
    .sync_oe(sync_oe), .sync_out(sync_out), .out_valid(out_valid),
    .out_sof(out_sof), .out_resync(out_resync), .out_use_in(out_use_in),
    .out_oh(out_oh), .out_kind(out_kind)
);

// File: tb/sim_tx_serial_in.sv
module sim_tx_serial_in;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic t1_mode = 1'b1, fall_edge = 1'b0, master = 1'b0, bypass = 1'b0;
    logic t1_fas_en = 1'b0, t1_dl_en = 1'b0, t1_crc_en = 1'b0, e1_oh_en = 1'b0;
    logic ser_clk = 1'b0, ser_data = 1'b0, sync_in = 1'b0;
    logic sync_out, sync_oe, out_valid, out_data, out_sof, out_use_in, out_oh, out_resync;
    logic line_clk, rail_p, rail_n;
    logic [4:0] out_slot;
    logic [2:0] out_bit;
    logic [1:0] out_kind;

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;

    always #2 clk = ~clk;

    tx_serial_in u0 (
        .clk(clk), .rst_n(rst_n), .t1_mode(t1_mode), .fall_edge(fall_edge),
        .master(master), .bypass(bypass), .t1_fas_en(t1_fas_en), .t1_dl_en(t1_dl_en),
        .t1_crc_en(t1_crc_en), .e1_oh_en(e1_oh_en), .ser_clk(ser_clk),
        .ser_data(ser_data), .sync_in(sync_in), .sync_out(sync_out), .sync_oe(sync_oe),
        .out_valid(out_valid), .out_data(out_data), .out_slot(out_slot), .out_bit(out_bit),
        .out_sof(out_sof), .out_use_in(out_use_in), .out_oh(out_oh), .out_kind(out_kind),
        .out_resync(out_resync), .line_clk(line_clk), .rail_p(rail_p), .rail_n(rail_n)
    );

    // behavioural reference state
    int m_pos = 0, m_mf = 23;
    bit m_prev = 0;
    int e_valid = 0, e_data = 0, e_slot = 0, e_bit = 0, e_sof = 0;
    int e_use = 0, e_oh = 0, e_kind = 0, e_resync = 0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pos = 0; m_mf = 23; m_prev = 0;
            e_valid = 0; e_data = 0; e_slot = 0; e_bit = 0; e_sof = 0;
            e_use = 0; e_oh = 0; e_kind = 0; e_resync = 0;
        end else begin
            bit edge_seen;
            int p, flen;
            edge_seen = fall_edge ? (m_prev && !ser_clk) : (!m_prev && ser_clk);
            m_prev = ser_clk;
            e_valid = 0; e_sof = 0; e_resync = 0;
            if (edge_seen && !bypass) begin
                flen = t1_mode ? 193 : 256;
                p = m_pos;
                if (!master && sync_in) begin
                    e_resync = (m_pos != 0);
                    p = 0;
                end
                if (p == 0) m_mf = (m_mf == 23) ? 0 : m_mf + 1;
                e_valid = 1; e_sof = (p == 0); e_data = ser_data;
                e_kind = 0; e_oh = 0; e_use = 1;
                if (t1_mode) begin
                    if (p == 0) begin
                        e_slot = 24; e_bit = 0; e_oh = 1;
                        case (m_mf % 4)
                            1: begin e_kind = 3; e_use = t1_crc_en; end
                            3: begin e_kind = 1; e_use = t1_fas_en; end
                            default: begin e_kind = 2; e_use = t1_dl_en; end
                        endcase
                    end else begin
                        e_slot = (p - 1) / 8; e_bit = (p - 1) % 8;
                    end
                end else begin
                    e_slot = p / 8; e_bit = p % 8;
                    if (e_slot == 0 || e_slot == 16) begin e_oh = 1; e_use = e1_oh_en; end
                end
                m_pos = (p + 1) % flen;
            end
        end
        #1;
        if (!done) begin
            string rq_fmt, rq_oh;
            rq_fmt = !rst_n ? "R1" : (t1_mode ? "R3" : "R4");
            rq_oh  = !rst_n ? "R1" : (t1_mode ? "R8" : "R7");
            vectors++;
            chk(!rst_n ? "R1" : "R2", "valid", out_valid, e_valid);
            chk(!rst_n ? "R1" : "R2", "data", out_data, e_data);
            chk(rq_fmt, "slot", out_slot, e_slot);
            chk(rq_fmt, "bit", out_bit, e_bit);
            chk(!rst_n ? "R1" : "R10", "sof", out_sof, e_sof);
            chk(!rst_n ? "R1" : "R5", "resync", out_resync, e_resync);
            chk(rq_oh, "use_in", out_use_in, e_use);
            chk(rq_oh, "oh", out_oh, e_oh);
            chk(!rst_n ? "R1" : "R8", "kind", out_kind, e_kind);
            chk("R6", "sync_oe", sync_oe, master && !bypass);
            chk("R6", "sync_out", sync_out, master && !bypass && m_pos == 0);
            chk("R9", "rail_p", rail_p, bypass && ser_data);
            chk("R9", "rail_n", rail_n, bypass && sync_in);
            chk("R9", "line_clk", line_clk, bypass && ser_clk);
        end
    end

    task automatic do_reset(input bit t1, input bit fe, input bit mst, input bit byp,
                            input bit fas, input bit dl, input bit crc, input bit e1oh);
        rst_n = 1'b0;
        t1_mode = t1; fall_edge = fe; master = mst; bypass = byp;
        t1_fas_en = fas; t1_dl_en = dl; t1_crc_en = crc; e1_oh_en = e1oh;
        ser_clk = 1'b0; ser_data = 1'b0; sync_in = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // one serial period: idle phase then the capturing phase
    task automatic ser_bit(input bit d, input bit s);
        ser_data = d; sync_in = s;
        ser_clk = fall_edge;
        repeat (2) @(negedge clk);
        ser_clk = ~fall_edge;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        @(negedge clk);
        // R1: reset state observed while held
        do_reset(1, 0, 0, 0, 1, 0, 0, 0);
        // R3 R5 R8 R10: T1 slave, aligned pulses every wrap
        for (int i = 0; i < 193 * 3; i++) ser_bit($urandom_range(0, 1), (i % 193) == 0);
        // R5: early pulse 50 bits in, then a wrap with no pulse
        for (int i = 0; i < 50; i++) ser_bit($urandom_range(0, 1), 1'b0);
        ser_bit(1'b1, 1'b1);
        for (int i = 0; i < 200; i++) ser_bit($urandom_range(0, 1), 1'b0);

        // R2 R4 R7: E1 slave, falling edge, slot 0/16 replaced
        do_reset(0, 1, 0, 0, 0, 0, 0, 0);
        for (int i = 0; i < 256 * 2; i++) ser_bit($urandom_range(0, 1), (i % 256) == 0);
        ser_bit(1'b0, 1'b1);
        for (int i = 0; i < 40; i++) ser_bit($urandom_range(0, 1), 1'b0);
        // R7: slot 0/16 taken from input
        do_reset(0, 1, 0, 0, 0, 0, 0, 1);
        for (int i = 0; i < 266; i++) ser_bit($urandom_range(0, 1), i == 0);

        // R6 R8: T1 master over a full multiframe, input pulse noise ignored
        do_reset(1, 0, 1, 0, 0, 1, 1, 0);
        for (int i = 0; i < 193 * 25; i++) ser_bit($urandom_range(0, 1), $urandom_range(0, 1));

        // R6: E1 master on falling edge
        do_reset(0, 1, 1, 0, 0, 0, 0, 1);
        for (int i = 0; i < 300; i++) ser_bit($urandom_range(0, 1), $urandom_range(0, 1));

        // R9: bypass routes pins, no capture
        do_reset(1, 0, 1, 1, 1, 1, 1, 1);
        for (int i = 0; i < 120; i++) begin
            ser_data = 1'($urandom_range(0, 1));
            sync_in  = 1'($urandom_range(0, 1));
            ser_clk  = 1'($urandom_range(0, 1));
            repeat (2) @(negedge clk);
        end

        repeat (4) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            miscompares++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule